// File: doc/BRIEF.md
# Bit-Field and Byte-Reorder Unit

This is a purely combinational 32-bit bit-manipulation datapath. An opcode selects one operation. There are two field operations: clearing a span of the destination word, or inserting low source bits into that span. There are four reorder operations on the source word: reverse all bits, reverse all bytes, swap the bytes within each half-word, and swap the two low bytes with sign extension. There are also four extension operations: the source is first rotated right by a whole number of bytes, then its low byte or low half-word is sign- or zero-extended.

The span for the field operations is given by a start bit (`fld_lsb_i`, 0..31) and a length (`fld_len_i`, 1..32). A span that is empty or runs past bit 31 is treated as illegal, and the destination is then returned unchanged. An execute stage drives the operands and takes `result_o` in the same cycle.

Top module: `bitmanip_unit`

## Requirements
- R1: `op_i` encoding: 0 field clear, 1 field insert, 2 bit reverse, 3 word byte reverse, 4 half-word byte swap, 5 low half-word byte swap with sign extension, 6 sign-extend byte, 7 sign-extend half-word, 8 zero-extend byte, 9 zero-extend half-word. Codes 10..15 return `dst_i` unchanged.
- R2: Field clear returns `dst_i` with bits [lsb+len-1 : lsb] forced to 0 and every other bit kept. For example, lsb 8 and len 12 on 0xFFFFFFFF gives 0xFFF000FF.
- R3: Field insert places `src_i[len-1:0]` at bits [lsb+len-1 : lsb] of `dst_i` and keeps every other bit of `dst_i`.
- R4: If len is 0, or lsb+len exceeds 32, both field operations return `dst_i` unchanged.
- R5: Bit reverse sets result bit i to `src_i` bit 31-i, so 0x12345678 gives 0x1E6A2C48.
- R6: Word byte reverse maps 0x12345678 to 0x78563412.
- R7: Half-word byte swap exchanges the two bytes inside each 16-bit half on its own, so 0x12345678 gives 0x34127856.
- R8: Signed low-half swap exchanges bytes 0 and 1 of `src_i` and copies the new bit 15 into bits 31..16, so 0x33448899 gives 0xFFFF9988.
- R9: Sign extension rotates `src_i` right by 8×`rot_i`, then copies bit 7 (byte form) or bit 15 (half form) of the rotated value into all bits above it. For 0x55AA8765 with `rot_i`=0, the byte form gives 0x00000065 and the half form gives 0xFFFF8765.
- R10: Zero extension uses the same rotation and clears all bits above bit 7 (byte form) or bit 15 (half form). For 0x55AA8765 with `rot_i`=0, the results are 0x00000065 and 0x00008765.
- R11: `rot_i` has no effect outside the extension operations. `fld_lsb_i` and `fld_len_i` have no effect outside the field operations. `dst_i` has no effect on the reorder and extension operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation select (encoding in R1) |
| dst_i | input | 32 | Destination word for field ops and reserved codes |
| src_i | input | 32 | Source word |
| fld_lsb_i | input | 5 | Lowest bit of the field span |
| fld_len_i | input | 6 | Field length, 1..32 legal |
| rot_i | input | 2 | Byte rotate amount before extension |
| result_o | output | 32 | Operation result |

## Verification
The embedded assertions check several invariants whenever the inputs settle. Field clear never sets a bit. Field insert never changes a bit outside its span. An illegal span or a reserved code passes the destination through. The three reorder forms keep the source's population count. The extended results have a uniform upper part. These checks cannot show that bits land in the correct positions, that the rotation amount is right, or that unused operands are ignored. The bench's scenarios cover those: the worked example words, the span limits (lsb 31 with length 1, length 32, one bit past the end), every rotation of the extension forms, and a run of pseudo-random operands compared with an independent bit-loop model.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  typedef enum logic [3:0] {
    OP_FCLR     = 4'd0,
    OP_FINS     = 4'd1,
    OP_BREV     = 4'd2,
    OP_BSWAP    = 4'd3,
    OP_HSWAP    = 4'd4,
    OP_HSWAP_SX = 4'd5,
    OP_SEXT_B   = 4'd6,
    OP_SEXT_H   = 4'd7,
    OP_ZEXT_B   = 4'd8,
    OP_ZEXT_H   = 4'd9
  } bmu_op_e;
endpackage

// File: rtl/bmu_field.sv
module bmu_field #(
  parameter int DATA_W = 32,
  localparam int LSB_W = $clog2(DATA_W),
  localparam int LEN_W = LSB_W + 1
) (
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [LSB_W-1:0]  lsb_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              insert_i,
  output logic              legal_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] result_o
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [LEN_W:0]      span_end;
  logic [DATA_W-1:0]   low_mask;
  logic [DATA_W-1:0]   kept;
  logic [DATA_W-1:0]   placed;

  always_comb begin
    span_end = {2'b00, lsb_i} + {1'b0, len_i};
    legal_o  = (len_i != '0) && (span_end <= (LEN_W+1)'(DATA_W));
    if (len_i >= LEN_W'(DATA_W)) low_mask = ALL_ONES;
    else                         low_mask = ~(ALL_ONES << len_i);
    mask_o   = legal_o ? (low_mask << lsb_i) : '0;
    kept     = dst_i & ~mask_o;
    placed   = insert_i ? ((src_i << lsb_i) & mask_o) : '0;
    result_o = kept | placed;
  end
endmodule

// File: rtl/bmu_reorder.sv
module bmu_reorder #(
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int NHALF  = DATA_W / 16
) (
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] brev_o,
  output logic [DATA_W-1:0] bswap_o,
  output logic [DATA_W-1:0] hswap_o,
  output logic [DATA_W-1:0] hswap_sx_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign brev_o[i] = src_i[DATA_W-1-i];
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign bswap_o[8*b +: 8] = src_i[8*(NBYTES-1-b) +: 8];
  end

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign hswap_o[16*h +: 8]     = src_i[16*h+8 +: 8];
    assign hswap_o[16*h+8 +: 8]   = src_i[16*h +: 8];
  end

  assign hswap_sx_o = {{(DATA_W-16){src_i[7]}}, src_i[7:0], src_i[15:8]};
endmodule

// File: rtl/bmu_extend.sv
module bmu_extend #(
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int ROT_W  = $clog2(NBYTES)
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [ROT_W-1:0]  rot_i,
  output logic [DATA_W-1:0] sext_b_o,
  output logic [DATA_W-1:0] sext_h_o,
  output logic [DATA_W-1:0] zext_b_o,
  output logic [DATA_W-1:0] zext_h_o
);
  logic [DATA_W-1:0] rot_opt [NBYTES];
  logic [DATA_W-1:0] rotated;

  for (genvar k = 0; k < NBYTES; k++) begin : g_rot
    if (k == 0) begin : g_none
      assign rot_opt[k] = src_i;
    end else begin : g_some
      assign rot_opt[k] = {src_i[8*k-1:0], src_i[DATA_W-1:8*k]};
    end
  end

  assign rotated  = rot_opt[rot_i];
  assign sext_b_o = {{(DATA_W-8){rotated[7]}}, rotated[7:0]};
  assign sext_h_o = {{(DATA_W-16){rotated[15]}}, rotated[15:0]};
  assign zext_b_o = {{(DATA_W-8){1'b0}}, rotated[7:0]};
  assign zext_h_o = {{(DATA_W-16){1'b0}}, rotated[15:0]};
endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit #(
  parameter int DATA_W = 32,
  localparam int LSB_W  = $clog2(DATA_W),
  localparam int LEN_W  = LSB_W + 1,
  localparam int ROT_W  = $clog2(DATA_W / 8)
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [LSB_W-1:0]  fld_lsb_i,
  input  logic [LEN_W-1:0]  fld_len_i,
  input  logic [ROT_W-1:0]  rot_i,
  output logic [DATA_W-1:0] result_o
);
  import bmu_pkg::*;

  bmu_op_e           op;
  logic              fld_legal;
  logic [DATA_W-1:0] fld_mask, fld_res;
  logic [DATA_W-1:0] brev, bswap, hswap, hswap_sx;
  logic [DATA_W-1:0] sext_b, sext_h, zext_b, zext_h;

  assign op = bmu_op_e'(op_i);

  bmu_field #(.DATA_W(DATA_W)) u_field (
    .dst_i(dst_i), .src_i(src_i), .lsb_i(fld_lsb_i), .len_i(fld_len_i),
    .insert_i(op == OP_FINS), .legal_o(fld_legal), .mask_o(fld_mask),
    .result_o(fld_res)
  );

  bmu_reorder #(.DATA_W(DATA_W)) u_reorder (
    .src_i(src_i), .brev_o(brev), .bswap_o(bswap), .hswap_o(hswap),
    .hswap_sx_o(hswap_sx)
  );

  bmu_extend #(.DATA_W(DATA_W)) u_extend (
    .src_i(src_i), .rot_i(rot_i), .sext_b_o(sext_b), .sext_h_o(sext_h),
    .zext_b_o(zext_b), .zext_h_o(zext_h)
  );

  always_comb begin
    case (op)
      OP_FCLR, OP_FINS: result_o = fld_res;
      OP_BREV:          result_o = brev;
      OP_BSWAP:         result_o = bswap;
      OP_HSWAP:         result_o = hswap;
      OP_HSWAP_SX:      result_o = hswap_sx;
      OP_SEXT_B:        result_o = sext_b;
      OP_SEXT_H:        result_o = sext_h;
      OP_ZEXT_B:        result_o = zext_b;
      OP_ZEXT_H:        result_o = zext_h;
      default:          result_o = dst_i;
    endcase
  end

  // Invariants checked whenever the operands settle.
  always_comb begin
    if (op_i > 4'd9)
      assert_reserved_pass_R1: assert (result_o == dst_i)
        else $error("reserved opcode altered destination");
    if (op == OP_FCLR)
      assert_clear_no_set_R2: assert ((result_o & ~dst_i) == '0)
        else $error("field clear set a bit");
    if (op == OP_FINS && fld_legal)
      assert_insert_outside_R3: assert (((result_o ^ dst_i) & ~fld_mask) == '0)
        else $error("field insert touched bits outside span");
    if ((op == OP_FCLR || op == OP_FINS) && !fld_legal)
      assert_illegal_span_R4: assert (result_o == dst_i)
        else $error("illegal span altered destination");
    if (op == OP_BREV)
      assert_brev_pop_R5: assert ($countones(result_o) == $countones(src_i))
        else $error("bit reverse changed population");
    if (op == OP_BSWAP)
      assert_bswap_pop_R6: assert ($countones(result_o) == $countones(src_i))
        else $error("byte reverse changed population");
    if (op == OP_HSWAP)
      assert_hswap_pop_R7: assert ($countones(result_o) == $countones(src_i))
        else $error("half swap changed population");
    if (op == OP_HSWAP_SX)
      assert_hswap_sx_upper_R8: assert ((&result_o[DATA_W-1:15]) || !(|result_o[DATA_W-1:15]))
        else $error("signed half swap upper bits not uniform");
    if (op == OP_SEXT_B)
      assert_sext_b_upper_R9: assert ((&result_o[DATA_W-1:7]) || !(|result_o[DATA_W-1:7]))
        else $error("sign byte upper bits not uniform");
    if (op == OP_SEXT_H)
      assert_sext_h_upper_R9: assert ((&result_o[DATA_W-1:15]) || !(|result_o[DATA_W-1:15]))
        else $error("sign half upper bits not uniform");
    if (op == OP_ZEXT_B)
      assert_zext_b_upper_R10: assert (result_o[DATA_W-1:8] == '0)
        else $error("zero byte upper bits set");
    if (op == OP_ZEXT_H)
      assert_zext_h_upper_R10: assert (result_o[DATA_W-1:16] == '0)
        else $error("zero half upper bits set");
  end
endmodule

// File: tb/bitmanip_unit_bench.sv
module bitmanip_unit_bench;
  logic        clk;
  logic        rst_n;
  logic [3:0]  op;
  logic [31:0] dst, src;
  logic [4:0]  lsb;
  logic [5:0]  len;
  logic [1:0]  rot;
  logic [31:0] result;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  int          n_checks = 0;
  int          n_fails  = 0;
  bit          done     = 0;

  bitmanip_unit u_bitmanip_unit (
    .op_i(op), .dst_i(dst), .src_i(src), .fld_lsb_i(lsb),
    .fld_len_i(len), .rot_i(rot), .result_o(result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] d,
                                        input logic [31:0] s, input int lo, input int ln,
                                        input int r);
    logic [31:0] v, t;
    v = d;
    case (o)
      4'd0, 4'd1: begin
        if (ln != 0 && lo + ln <= 32)
          for (int i = lo; i < lo + ln; i++) v[i] = (o == 4'd1) ? s[i-lo] : 1'b0;
      end
      4'd2: for (int i = 0; i < 32; i++) v[i] = s[31-i];
      4'd3: v = {s[7:0], s[15:8], s[23:16], s[31:24]};
      4'd4: v = {s[23:16], s[31:24], s[7:0], s[15:8]};
      4'd5: v = {{16{s[7]}}, s[7:0], s[15:8]};
      4'd6, 4'd7, 4'd8, 4'd9: begin
        for (int i = 0; i < 32; i++) t[i] = s[(i + 8*r) % 32];
        case (o)
          4'd6: v = {{24{t[7]}}, t[7:0]};
          4'd7: v = {{16{t[15]}}, t[15:0]};
          4'd8: v = {24'h0, t[7:0]};
          default: v = {16'h0, t[15:0]};
        endcase
      end
      default: v = d;
    endcase
    return v;
  endfunction

  function automatic string op_tag(input logic [3:0] o);
    case (o)
      4'd0: return "R2";  4'd1: return "R3";  4'd2: return "R5";
      4'd3: return "R6";  4'd4: return "R7";  4'd5: return "R8";
      4'd6, 4'd7: return "R9";
      4'd8, 4'd9: return "R10";
      default: return "R1";
    endcase
  endfunction

  task automatic drive(input logic [3:0] o, input logic [31:0] d, input logic [31:0] s,
                       input int lo, input int ln, input int r,
                       input logic [31:0] expv, input string tag);
    @(negedge clk);
    op = o; dst = d; src = s; lsb = 5'(lo); len = 6'(ln); rot = 2'(r);
    exp_q.push_back(expv);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares at the edge after each drive.
  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string       t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (result !== e) begin
        n_fails++;
        $display("FAIL %s: op=%0d got %08h expected %08h", t, op, result, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op = 4'd15; dst = 32'hCAFE_F00D; src = 32'h0; lsb = '0; len = '0; rot = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R1: reserved codes pass destination
    drive(4'd15, 32'hCAFEF00D, 32'h12345678, 3, 4, 1, 32'hCAFEF00D, "R1");
    drive(4'd10, 32'h0BADBEEF, 32'hFFFFFFFF, 0, 32, 2, 32'h0BADBEEF, "R1");
    // R2: field clear
    drive(4'd0, 32'hFFFFFFFF, 32'h0, 8, 12, 0, 32'hFFF000FF, "R2");
    drive(4'd0, 32'hFFFFFFFF, 32'h0, 31, 1, 0, 32'h7FFFFFFF, "R2");
    drive(4'd0, 32'hA5A5A5A5, 32'h0, 0, 32, 0, 32'h00000000, "R2");
    // R3: field insert
    drive(4'd1, 32'h00000000, 32'hFFFFFABC, 8, 12, 0, 32'h000ABC00, "R3");
    drive(4'd1, 32'hFFFFFFFF, 32'h00000000, 0, 32, 0, 32'h00000000, "R3");
    drive(4'd1, 32'h12345678, 32'hFFFFFFF0, 28, 4, 0, 32'h02345678, "R3");
    // R4: illegal spans
    drive(4'd0, 32'hDEADBEEF, 32'h0, 20, 13, 0, 32'hDEADBEEF, "R4");
    drive(4'd1, 32'hDEADBEEF, 32'hFFFFFFFF, 4, 0, 0, 32'hDEADBEEF, "R4");
    drive(4'd1, 32'h13572468, 32'hFFFFFFFF, 31, 2, 0, 32'h13572468, "R4");
    // R5..R8: reorders
    drive(4'd2, 32'h0, 32'h12345678, 0, 0, 0, 32'h1E6A2C48, "R5");
    drive(4'd3, 32'h0, 32'h12345678, 0, 0, 0, 32'h78563412, "R6");
    drive(4'd4, 32'h0, 32'h12345678, 0, 0, 0, 32'h34127856, "R7");
    drive(4'd5, 32'h0, 32'h33448899, 0, 0, 0, 32'hFFFF9988, "R8");
    drive(4'd5, 32'h0, 32'hFFFF7F01, 0, 0, 0, 32'h0000017F, "R8");
    // R9/R10: extension, all rotations
    drive(4'd6, 32'h0, 32'h55AA8765, 0, 0, 0, 32'h00000065, "R9");
    drive(4'd7, 32'h0, 32'h55AA8765, 0, 0, 0, 32'hFFFF8765, "R9");
    drive(4'd8, 32'h0, 32'h55AA8765, 0, 0, 0, 32'h00000065, "R10");
    drive(4'd9, 32'h0, 32'h55AA8765, 0, 0, 0, 32'h00008765, "R10");
    drive(4'd6, 32'h0, 32'h55AA8765, 0, 0, 1, 32'hFFFFFF87, "R9");
    drive(4'd9, 32'h0, 32'h55AA8765, 0, 0, 1, 32'h0000AA87, "R10");
    drive(4'd7, 32'h0, 32'h55AA8765, 0, 0, 2, 32'h000055AA, "R9");
    drive(4'd8, 32'h0, 32'h55AA8765, 0, 0, 2, 32'h000000AA, "R10");
    drive(4'd7, 32'h0, 32'h55AA8765, 0, 0, 3, 32'h00006555, "R9");
    drive(4'd8, 32'h0, 32'h55AA8765, 0, 0, 3, 32'h00000055, "R10");
    // R11: unused operands ignored
    drive(4'd2, 32'hFFFFFFFF, 32'h12345678, 17, 9, 3, 32'h1E6A2C48, "R11");
    drive(4'd3, 32'hAAAA5555, 32'h12345678, 5, 20, 2, 32'h78563412, "R11");
    drive(4'd0, 32'hFFFFFFFF, 32'h12345678, 8, 12, 3, 32'hFFF000FF, "R11");
    drive(4'd8, 32'h99999999, 32'h55AA8765, 31, 32, 0, 32'h00000065, "R11");
    // Pseudo-random sweep against the bit-loop model
    for (int n = 0; n < 400; n++) begin
      logic [3:0]  o;
      logic [31:0] d, s;
      int lo, ln, r;
      o  = 4'($urandom_range(0, 11));
      d  = $urandom();
      s  = $urandom();
      lo = $urandom_range(0, 31);
      ln = $urandom_range(0, 32);
      r  = $urandom_range(0, 3);
      drive(o, d, s, lo, ln, r, model(o, d, s, lo, ln, r), op_tag(o));
    end
    @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule